// File: doc/BRIEF.md
# Calibrated Real-Time Clock Core

This block keeps the time of day and the calendar date in packed BCD. A one-cycle enable, `osc_tick`, arrives at the crystal rate. A two-stage prescaler divides it down to one pulse per second. The first stage divides by `FINE_DIV`, and its output is the point where calibration acts. The second stage divides by `COARSE_DIV`. Each second pulse drives a carry chain through the calendar fields: seconds, minutes, 24-hour hours, day of week, date, month and two-digit year. The chain knows each month's length and handles leap years. A century flag can toggle when the year wraps.

Software, or a serial front end placed ahead of this core, reaches eight byte-wide registers through a small access port. Opening an access takes a snapshot of all eight registers. The address can be loaded at that point or can continue from where the last access stopped. Each following read or write moves the address on by one. When the supply-good input drops, the port locks: writes and reads are ignored, the address returns to zero and the open access is closed.

The port is built around a three-state machine:
- `PORT_IDLE`: no access is open. It moves to `PORT_OPEN` when `acc_start` arrives.
- `PORT_OPEN`: an access is open. A new `acc_start` keeps it in `PORT_OPEN` and takes a fresh snapshot.
- `PORT_LOCK`: entered from either state when `pwr_good` is low. It returns to `PORT_IDLE` once `pwr_good` is high again.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset, reads return these values: 0x00 (seconds), 0x00 (minutes), 0x00 (hours), 0x01 (day of week), 0x01 (date), 0x01 (month), 0x00 (year) and 0x80 (control).
- R2: Register layout. Address 0 holds the stop flag in bit 7 and seconds in bits 6:0. Address 1 holds minutes. Address 2 holds the century-enable flag in bit 7, the century flag in bit 6 and hours 00–23 in bits 5:0. Address 3 holds the day of week, 1–7, in bits 2:0. Address 4 holds the date, 5 the month and 6 the year. Address 7 is control: bit 7 is the pin level, bit 6 enables the test frequency, bit 5 is the calibration sign (1 = faster) and bits 4:0 are the calibration magnitude. All time values are BCD.
- R3: One second passes every FINE_DIV×COARSE_DIV oscillator ticks. Seconds and minutes wrap 59→00 and carry on; hours wrap 23→00 and carry on; the day of week wraps 7→1.
- R4: The date wraps to 01 after the last day of the month and the month moves on. April, June, September and November have 30 days. February has 29 days when the year is divisible by four (00 included) and 28 days otherwise. December wraps to January and the year moves on.
- R5: When the year wraps 99→00, the century flag inverts if century-enable is 1 and keeps its value if century-enable is 0.
- R6: While the stop flag is 1, time does not advance. Writing address 0 clears the prescaler, so the next second arrives one full period after that write.
- R7: `acc_start` opens an access. It loads the address from `acc_addr` when `acc_load` is 1 and otherwise keeps the current address. Each read or write moves the address on by one, with 7 wrapping to 0. Read data appears one cycle after `acc_rd`.
- R8: The values an open access reads back are those captured at `acc_start`. Time that passes during the access does not change them.
- R9: When the test-frequency flag is 0, `freq_out` equals the pin-level bit. When it is 1 and time is running, `freq_out` toggles once every FINE_DIV ticks. When it is 1 and time is stopped, `freq_out` equals the pin-level bit.
- R10: With sign 1 and magnitude M, each calibration period of CAL_PERIOD_S seconds is split into 32 slots. In each of the first M slots, one extra coarse count is inserted. With FINE_DIV=4, COARSE_DIV=4 and M=31, minute 01 second 02 is reached after 868 ticks.
- R11: With sign 0 and magnitude M, one coarse count is removed in each of the first M slots. With the same settings, minute 01 second 02 is reached after 1116 ticks.
- R12: While `pwr_good` is 0, writes and reads are ignored, `acc_rdata` holds its value, the address is reset to 0 and the open access is closed. After `pwr_good` returns, `acc_rd` has no effect until a new `acc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Oscillator-rate count enable |
| pwr_good | input | 1 | Supply good; low locks the access port |
| acc_start | input | 1 | Open an access and snapshot the registers |
| acc_load | input | 1 | With acc_start, load the address from acc_addr |
| acc_addr | input | 3 | Start address |
| acc_rd | input | 1 | Read one byte and move the address on |
| acc_wr | input | 1 | Write one byte and move the address on |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered |
| freq_out | output | 1 | Level or test-frequency pin |

## Verification
Read data is due one cycle after `acc_rd`. A second's calendar update lands one cycle after the edge that carries the last tick of that second. The pin follows a control write as soon as that write's clock edge has passed.

The bench drives stimulus on falling edges and samples one falling edge after the edge that produces a result. It holds `osc_tick` low except inside counted bursts, so every time check knows exactly how many ticks have passed. Before reading the calendar it waits two idle cycles. The calibration checks sample halfway through the expected second, so the result does not depend on the few cycles of port overhead.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef logic [7:0][7:0] rtc_bank_t;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_OPEN,
        PORT_LOCK
    } port_state_e;

    localparam logic [2:0] A_SEC  = 3'd0;
    localparam logic [2:0] A_MIN  = 3'd1;
    localparam logic [2:0] A_HOUR = 3'd2;
    localparam logic [2:0] A_DOW  = 3'd3;
    localparam logic [2:0] A_DATE = 3'd4;
    localparam logic [2:0] A_MON  = 3'd5;
    localparam logic [2:0] A_YEAR = 3'd6;
    localparam logic [2:0] A_CTL  = 3'd7;

    // BCD increment of a two-digit value (no wrap handling)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four
    function automatic logic yr_is_leap(input logic [7:0] yr);
        if (yr[4] == 1'b0)
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        else
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    // Last date of a BCD month
    function automatic logic [5:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
        case (mon)
            5'h02:                      return yr_is_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned FINE_DIV     = 256,
    parameter int unsigned COARSE_DIV   = 128,
    parameter int unsigned CAL_PERIOD_S = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       run,
    input  logic       clr,
    input  logic       cal_sign,
    input  logic [4:0] cal_mag,
    output logic       sec_tick,
    output logic       sq
);
    localparam int unsigned FW     = (FINE_DIV > 2) ? $clog2(FINE_DIV) : 1;
    localparam int unsigned CW     = $clog2(COARSE_DIV + 2);
    localparam int unsigned SW     = (CAL_PERIOD_S > 2) ? $clog2(CAL_PERIOD_S) : 1;
    localparam int unsigned SLOT_S = (CAL_PERIOD_S >= 32) ? CAL_PERIOD_S / 32 : 1;

    logic [FW-1:0] fine;
    logic [CW-1:0] coarse;
    logic [SW-1:0] cal_sec;
    logic          cor_done;

    logic          fine_wrap;
    logic          apply_cor;
    logic [1:0]    inc;
    logic [CW-1:0] sum;
    logic          sum_wrap;
    logic [SW-1:0] cal_sec_n;
    logic [SW-1:0] slot;

    always_comb begin
        fine_wrap = (fine == FW'(FINE_DIV - 1));
        slot      = cal_sec / SW'(SLOT_S);
        apply_cor = !cor_done && (32'(slot) < 32'(cal_mag));
        if (apply_cor)
            inc = cal_sign ? 2'd2 : 2'd0;
        else
            inc = 2'd1;
        sum       = coarse + CW'(inc);
        sum_wrap  = (sum >= CW'(COARSE_DIV));
        cal_sec_n = (cal_sec == SW'(CAL_PERIOD_S - 1)) ? '0 : cal_sec + SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine     <= '0;
            coarse   <= '0;
            cal_sec  <= '0;
            cor_done <= 1'b0;
            sec_tick <= 1'b0;
            sq       <= 1'b0;
        end else begin
            sec_tick <= 1'b0;
            if (clr) begin
                fine     <= '0;
                coarse   <= '0;
                cal_sec  <= '0;
                cor_done <= 1'b0;
            end else if (osc_tick && run) begin
                if (fine_wrap) begin
                    fine <= '0;
                    sq   <= ~sq;
                    if (apply_cor)
                        cor_done <= 1'b1;
                    if (sum_wrap) begin
                        coarse   <= sum - CW'(COARSE_DIV);
                        sec_tick <= 1'b1;
                        cal_sec  <= cal_sec_n;
                        if ((32'(cal_sec_n) % SLOT_S) == 0)
                            cor_done <= 1'b0;
                    end else begin
                        coarse <= sum;
                    end
                end else begin
                    fine <= fine + FW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output rtc_bank_t  bank,
    output logic       sec_wr
);
    logic       stop, n_stop;
    logic [6:0] sec,  n_sec;
    logic [6:0] min,  n_min;
    logic [5:0] hr,   n_hr;
    logic       ceb,  n_ceb;
    logic       cb,   n_cb;
    logic [2:0] dow,  n_dow;
    logic [5:0] date, n_date;
    logic [4:0] mon,  n_mon;
    logic [7:0] yr,   n_yr;
    logic [7:0] ctl,  n_ctl;

    always_comb begin
        n_stop = stop; n_sec = sec; n_min = min; n_hr = hr; n_ceb = ceb;
        n_cb = cb; n_dow = dow; n_date = date; n_mon = mon; n_yr = yr; n_ctl = ctl;
        if (sec_tick) begin
            if (sec == 7'h59) begin
                n_sec = 7'h00;
                if (min == 7'h59) begin
                    n_min = 7'h00;
                    if (hr == 6'h23) begin
                        n_hr  = 6'h00;
                        n_dow = (dow == 3'd7) ? 3'd1 : dow + 3'd1;
                        if (date == month_end(mon, yr)) begin
                            n_date = 6'h01;
                            if (mon == 5'h12) begin
                                n_mon = 5'h01;
                                if (yr == 8'h99) begin
                                    n_yr = 8'h00;
                                    if (ceb)
                                        n_cb = ~cb;
                                end else begin
                                    n_yr = bcd_inc(yr);
                                end
                            end else begin
                                n_mon = 5'(bcd_inc({3'b000, mon}));
                            end
                        end else begin
                            n_date = 6'(bcd_inc({2'b00, date}));
                        end
                    end else begin
                        n_hr = 6'(bcd_inc({2'b00, hr}));
                    end
                end else begin
                    n_min = 7'(bcd_inc({1'b0, min}));
                end
            end else begin
                n_sec = 7'(bcd_inc({1'b0, sec}));
            end
        end
        if (wr_en) begin
            unique case (wr_addr)
                A_SEC:  begin n_stop = wr_data[7]; n_sec = wr_data[6:0]; end
                A_MIN:  n_min = wr_data[6:0];
                A_HOUR: begin n_ceb = wr_data[7]; n_cb = wr_data[6]; n_hr = wr_data[5:0]; end
                A_DOW:  n_dow = wr_data[2:0];
                A_DATE: n_date = wr_data[5:0];
                A_MON:  n_mon = wr_data[4:0];
                A_YEAR: n_yr = wr_data;
                A_CTL:  n_ctl = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop <= 1'b0; sec <= 7'h00; min <= 7'h00; hr <= 6'h00;
            ceb <= 1'b0; cb <= 1'b0; dow <= 3'd1; date <= 6'h01;
            mon <= 5'h01; yr <= 8'h00; ctl <= 8'h80;
        end else begin
            stop <= n_stop; sec <= n_sec; min <= n_min; hr <= n_hr;
            ceb <= n_ceb; cb <= n_cb; dow <= n_dow; date <= n_date;
            mon <= n_mon; yr <= n_yr; ctl <= n_ctl;
        end
    end

    assign sec_wr  = wr_en && (wr_addr == A_SEC);
    assign bank[0] = {stop, sec};
    assign bank[1] = {1'b0, min};
    assign bank[2] = {ceb, cb, hr};
    assign bank[3] = {5'b00000, dow};
    assign bank[4] = {2'b00, date};
    assign bank[5] = {3'b000, mon};
    assign bank[6] = yr;
    assign bank[7] = ctl;

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       acc_start,
    input  logic       acc_load,
    input  logic [2:0] acc_addr,
    input  logic       acc_rd,
    input  logic       acc_wr,
    input  logic [7:0] acc_wdata,
    input  rtc_bank_t  bank,
    output logic       wr_en,
    output logic [2:0] wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] rdata,
    output logic [2:0] addr
);
    port_state_e state, state_n;
    rtc_bank_t   snap;
    logic        take_start;
    logic        do_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PORT_IDLE;
        else
            state <= state_n;
    end

    always_comb begin
        state_n    = state;
        take_start = 1'b0;
        wr_en      = 1'b0;
        do_rd      = 1'b0;
        unique case (state)
            PORT_IDLE: begin
                if (!pwr_good) begin
                    state_n = PORT_LOCK;
                end else if (acc_start) begin
                    state_n    = PORT_OPEN;
                    take_start = 1'b1;
                end
            end
            PORT_OPEN: begin
                if (!pwr_good) begin
                    state_n = PORT_LOCK;
                end else if (acc_start) begin
                    take_start = 1'b1;
                end else begin
                    wr_en = acc_wr;
                    do_rd = acc_rd && !acc_wr;
                end
            end
            PORT_LOCK: begin
                if (pwr_good)
                    state_n = PORT_IDLE;
            end
            default: state_n = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= 3'd0;
            snap  <= '0;
            rdata <= 8'h00;
        end else begin
            if (!pwr_good)
                addr <= 3'd0;
            else if (take_start && acc_load)
                addr <= acc_addr;
            else if (wr_en || do_rd)
                addr <= addr + 3'd1;
            if (take_start)
                snap <= bank;
            if (do_rd)
                rdata <= snap[addr];
        end
    end

    assign wr_addr = addr;
    assign wr_data = acc_wdata;

endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_pkg::*;
#(
    parameter int unsigned FINE_DIV     = 256,
    parameter int unsigned COARSE_DIV   = 128,
    parameter int unsigned CAL_PERIOD_S = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       pwr_good,
    input  logic       acc_start,
    input  logic       acc_load,
    input  logic [2:0] acc_addr,
    input  logic       acc_rd,
    input  logic       acc_wr,
    input  logic [7:0] acc_wdata,
    output logic [7:0] acc_rdata,
    output logic       freq_out
);
    rtc_bank_t  bank;
    logic       port_wr;
    logic [2:0] port_wr_addr;
    logic [7:0] port_wr_data;
    logic [2:0] port_addr;
    logic       sec_wr;
    logic       sec_tick;
    logic       sq;
    logic       stop_bit;
    logic [7:0] ctl;
    logic [6:0] sec_bcd;
    logic [7:0] yr_bcd;
    logic       ceb_bit;
    logic       cb_bit;

    assign stop_bit = bank[0][7];
    assign ctl      = bank[7];
    assign sec_bcd  = bank[0][6:0];
    assign yr_bcd   = bank[6];
    assign ceb_bit  = bank[2][7];
    assign cb_bit   = bank[2][6];

    rtc_prescaler #(
        .FINE_DIV     (FINE_DIV),
        .COARSE_DIV   (COARSE_DIV),
        .CAL_PERIOD_S (CAL_PERIOD_S)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .run      (!stop_bit),
        .clr      (sec_wr),
        .cal_sign (ctl[5]),
        .cal_mag  (ctl[4:0]),
        .sec_tick (sec_tick),
        .sq       (sq)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .wr_en    (port_wr),
        .wr_addr  (port_wr_addr),
        .wr_data  (port_wr_data),
        .bank     (bank),
        .sec_wr   (sec_wr)
    );

    rtc_regport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .acc_start (acc_start),
        .acc_load  (acc_load),
        .acc_addr  (acc_addr),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .bank      (bank),
        .wr_en     (port_wr),
        .wr_addr   (port_wr_addr),
        .wr_data   (port_wr_data),
        .rdata     (acc_rdata),
        .addr      (port_addr)
    );

    assign freq_out = (ctl[6] && !stop_bit) ? sq : ctl[7];

endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic [7:0] acc_rdata,
    input logic       port_wr,
    input logic [2:0] port_addr,
    input logic       sec_tick,
    input logic       stop_bit,
    input logic [6:0] sec_bcd,
    input logic [7:0] yr_bcd,
    input logic       ceb_bit,
    input logic       cb_bit
);
    p_lock_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> !port_wr);

    p_lock_addr_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (port_addr == 3'd0));

    p_lock_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> $stable(acc_rdata));

    p_stop_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_bit |=> !sec_tick);

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !port_wr && sec_bcd == 7'h59) |=> (sec_bcd == 7'h00));

    p_century_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(yr_bcd) == 8'h99 && yr_bcd == 8'h00 && !$past(port_wr) && $past(ceb_bit))
        |-> (cb_bit != $past(cb_bit)));

    p_century_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(yr_bcd) == 8'h99 && yr_bcd == 8'h00 && !$past(port_wr) && !$past(ceb_bit))
        |-> (cb_bit == $past(cb_bit)));

endmodule

bind rtc_cal_core rtc_cal_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .acc_rdata (acc_rdata),
    .port_wr   (port_wr),
    .port_addr (port_addr),
    .sec_tick  (sec_tick),
    .stop_bit  (stop_bit),
    .sec_bcd   (sec_bcd),
    .yr_bcd    (yr_bcd),
    .ceb_bit   (ceb_bit),
    .cb_bit    (cb_bit)
);

// File: tb/rtc_cal_core_test.sv
module rtc_cal_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       pwr_good = 1'b1;
    logic       acc_start = 1'b0;
    logic       acc_load = 1'b0;
    logic [2:0] acc_addr = 3'd0;
    logic       acc_rd = 1'b0;
    logic       acc_wr = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] acc_rdata;
    logic       freq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    rtc_cal_core #(
        .FINE_DIV     (4),
        .COARSE_DIV   (4),
        .CAL_PERIOD_S (64)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .pwr_good  (pwr_good),
        .acc_start (acc_start),
        .acc_load  (acc_load),
        .acc_addr  (acc_addr),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .freq_out  (freq_out)
    );

    // start bytes {sec,min,hour,dow,date,month,year}, then expected after one second
    localparam logic [111:0] VEC [12] = '{
        {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00},
        {56'h59_34_12_03_15_06_21, 56'h00_35_12_03_15_06_21},
        {56'h59_59_09_02_10_03_22, 56'h00_00_10_02_10_03_22},
        {56'h59_59_23_07_30_04_21, 56'h00_00_00_01_01_05_21},
        {56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},
        {56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},
        {56'h59_59_23_03_29_02_24, 56'h00_00_00_04_01_03_24},
        {56'h59_59_A3_05_31_12_99, 56'h00_00_C0_06_01_01_00},
        {56'h59_59_63_05_31_12_99, 56'h00_00_40_06_01_01_00},
        {56'h59_59_23_01_31_01_05, 56'h00_00_00_02_01_02_05},
        {56'h59_59_23_04_28_02_00, 56'h00_00_00_05_29_02_00},
        {56'h59_59_23_06_30_09_17, 56'h00_00_00_07_01_10_17}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk) osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic open_acc(input logic ld, input logic [2:0] a);
        @(negedge clk);
        acc_start = 1'b1; acc_load = ld; acc_addr = a;
        @(negedge clk);
        acc_start = 1'b0; acc_load = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        b = acc_rdata;
    endtask

    task automatic rd_time(output logic [55:0] t);
        logic [7:0] b;
        open_acc(1'b1, 3'd0);
        t = '0;
        for (int i = 0; i < 7; i++) begin
            rd_byte(b);
            t = {t[47:0], b};
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] t;
        logic [7:0]  rb [8];
        int          toggles;
        logic        prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset values, R2 control layout
        check(freq_out == 1'b1, "R1 pin after reset", 64'(freq_out), 64'h1);
        open_acc(1'b1, 3'd0);
        for (int i = 0; i < 8; i++) begin
            rd_byte(b);
            rb[i] = b;
        end
        check({rb[0], rb[1], rb[2], rb[3], rb[4], rb[5], rb[6], rb[7]} == 64'h00_00_00_01_01_01_00_80,
              "R1 reset bank",
              {rb[0], rb[1], rb[2], rb[3], rb[4], rb[5], rb[6], rb[7]}, 64'h00_00_00_01_01_01_00_80);

        // R2 R3 R4 R5: one-second rollover vectors
        for (int v = 0; v < 12; v++) begin
            open_acc(1'b1, 3'd0);
            for (int i = 6; i >= 0; i--)
                wr_byte(VEC[v][56 + i*8 +: 8]);
            ticks(16);
            repeat (2) @(negedge clk);
            rd_time(t);
            check(t == VEC[v][55:0], $sformatf("R3 R4 R5 vector %0d", v), 64'(t), 64'(VEC[v][55:0]));
        end

        // R6 stop flag holds time, clearing resumes with a full second
        open_acc(1'b1, 3'd0);
        wr_byte(8'h90);
        ticks(40);
        repeat (2) @(negedge clk);
        open_acc(1'b1, 3'd0);
        rd_byte(b);
        check(b == 8'h90, "R6 stopped", 64'(b), 64'h90);
        open_acc(1'b1, 3'd0);
        wr_byte(8'h10);
        ticks(15);
        repeat (2) @(negedge clk);
        open_acc(1'b1, 3'd0);
        rd_byte(b);
        check(b == 8'h10, "R6 before full period", 64'(b), 64'h10);
        ticks(1);
        repeat (2) @(negedge clk);
        open_acc(1'b1, 3'd0);
        rd_byte(b);
        check(b == 8'h11, "R6 resumed", 64'(b), 64'h11);

        // R7 address wrap 7 -> 0 and current-address access
        open_acc(1'b1, 3'd7);
        rd_byte(b);
        check(b == 8'h80, "R7 control read", 64'(b), 64'h80);
        rd_byte(b);
        check(b == 8'h11, "R7 wrap to seconds", 64'(b), 64'h11);
        open_acc(1'b0, 3'd5);
        rd_byte(b);
        check(b == 8'h00, "R7 current address minutes", 64'(b), 64'h00);

        // R8 snapshot at access start
        open_acc(1'b1, 3'd0);
        wr_byte(8'h59);
        wr_byte(8'h00);
        ticks(15);
        open_acc(1'b1, 3'd0);
        ticks(3);
        repeat (2) @(negedge clk);
        rd_byte(b);
        rb[0] = b;
        rd_byte(b);
        check({rb[0], b} == 16'h5900, "R8 snapshot held", 64'({rb[0], b}), 64'h5900);
        open_acc(1'b1, 3'd0);
        rd_byte(b);
        rb[0] = b;
        rd_byte(b);
        check({rb[0], b} == 16'h0001, "R8 new snapshot", 64'({rb[0], b}), 64'h0001);

        // R9 pin behaviour
        open_acc(1'b1, 3'd7);
        wr_byte(8'h00);
        @(negedge clk);
        check(freq_out == 1'b0, "R9 level low", 64'(freq_out), 64'h0);
        open_acc(1'b1, 3'd7);
        wr_byte(8'h40);
        @(negedge clk);
        toggles = 0;
        prev = freq_out;
        osc_tick = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (freq_out != prev) toggles++;
            prev = freq_out;
        end
        osc_tick = 1'b0;
        check(toggles == 4, "R9 test frequency toggles", 64'(toggles), 64'd4);
        open_acc(1'b1, 3'd0);
        wr_byte(8'h80);
        @(negedge clk);
        check(freq_out == 1'b0, "R9 stopped follows level", 64'(freq_out), 64'h0);
        open_acc(1'b1, 3'd7);
        wr_byte(8'hC0);
        @(negedge clk);
        check(freq_out == 1'b1, "R9 stopped level high", 64'(freq_out), 64'h1);

        // R10 positive calibration, magnitude 31
        open_acc(1'b1, 3'd7);
        wr_byte(8'h3F);
        open_acc(1'b1, 3'd0);
        wr_byte(8'h00);
        wr_byte(8'h00);
        ticks(876);
        repeat (2) @(negedge clk);
        rd_time(t);
        check(t[55:40] == 16'h0201, "R10 faster", 64'(t[55:40]), 64'h0201);

        // R11 negative calibration, magnitude 31
        open_acc(1'b1, 3'd7);
        wr_byte(8'h1F);
        open_acc(1'b1, 3'd0);
        wr_byte(8'h00);
        wr_byte(8'h00);
        ticks(1124);
        repeat (2) @(negedge clk);
        rd_time(t);
        check(t[55:40] == 16'h0201, "R11 slower", 64'(t[55:40]), 64'h0201);

        // R12 power-fail lockout
        open_acc(1'b1, 3'd7);
        wr_byte(8'h80);
        open_acc(1'b1, 3'd0);
        wr_byte(8'h07);
        wr_byte(8'h45);
        open_acc(1'b1, 3'd1);
        rd_byte(b);
        check(b == 8'h45, "R12 setup minutes", 64'(b), 64'h45);
        @(negedge clk) pwr_good = 1'b0;
        open_acc(1'b1, 3'd1);
        wr_byte(8'h33);
        rd_byte(b);
        check(b == 8'h45, "R12 rdata held in lockout", 64'(b), 64'h45);
        @(negedge clk) pwr_good = 1'b1;
        repeat (2) @(negedge clk);
        rd_byte(b);
        check(b == 8'h45, "R12 read ignored after lockout", 64'(b), 64'h45);
        open_acc(1'b0, 3'd6);
        rd_byte(b);
        check(b == 8'h07, "R12 address reset to seconds", 64'(b), 64'h07);
        rd_byte(b);
        check(b == 8'h45, "R12 write ignored", 64'(b), 64'h45);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule